// File: doc/BRIEF.md
# Temperature Fault Status and Alert Unit

This block takes two signed temperature readings, one from the on-die sensor and one from a remote diode. When a reading's valid strobe is high, it compares that reading against a high limit and a low limit. A crossed limit, or an open remote diode, sets a sticky fault flag in an 8-bit status byte. The top bit of the byte shows whether the converter is busy.

Software reads the status byte and pulses a read strobe. The read clears each fault flag whose condition has gone away. A flag whose condition is still present stays set.

Independently of the flags, any fault event sets an alert latch. The latch drives a pull-low enable for a shared, wired-AND, active-low interrupt line. A status read does not release the latch. Only a read at the bus-wide alert-response address releases it, and only when no fault condition is still present. While the latch is set, the block presents a response byte that carries its 7-bit device address. When the latch is clear, the block does not answer the alert-response address.

Top module: `tsa_status_alert`

## Requirements
- R1: After reset, status bits 6..2 are 0, `alert_pull` is 0, `ara_ack` is 0 and `ara_byte` is 0.
- R2: The status layout is: bit 7 = live `adc_busy`, bit 6 = internal high, bit 5 = internal low, bit 4 = remote high, bit 3 = remote low, bit 2 = diode open, bits 1..0 always 0.
- R3: A high flag is set on the cycle after a strobed reading is greater than or equal to its high limit, compared as signed two's complement.
- R4: A low flag is set on the cycle after a strobed reading is less than or equal to its low limit, compared as signed two's complement.
- R5: A reading presented without its valid strobe neither sets a flag nor changes that reading's remembered condition.
- R6: The diode-open flag (bit 2) is set on the cycle after `diode_open` is 1, and the input is evaluated every cycle.
- R7: Fault flags are sticky. A `stat_rd` pulse clears a flag only if its condition no longer holds. For a limit flag the condition is the latest strobed comparison result. For the diode flag it is the live `diode_open` input.
- R8: When `stat_rd` and a new fault event fall in the same cycle, the flag for that fault ends up set.
- R9: `alert_pull` becomes 1 on the cycle after any fault event. The busy input never asserts it.
- R10: A `stat_rd` pulse never releases `alert_pull`.
- R11: An `ara_rd` pulse releases `alert_pull` only if no fault condition holds and no fault event occurs in that cycle.
- R12: While `alert_pull` is 1, `ara_byte` = {`dev_addr`, 1'b1} (address bit 6 in byte bit 7) and `ara_ack` = `ara_rd`. While `alert_pull` is 0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_temp | input | 8 | Internal reading, signed |
| int_vld | input | 1 | Internal reading valid strobe |
| rem_temp | input | 8 | Remote reading, signed |
| rem_vld | input | 1 | Remote reading valid strobe |
| int_hi_lim | input | 8 | Internal high limit, signed |
| int_lo_lim | input | 8 | Internal low limit, signed |
| rem_hi_lim | input | 8 | Remote high limit, signed |
| rem_lo_lim | input | 8 | Remote low limit, signed |
| diode_open | input | 1 | Remote diode disconnected |
| adc_busy | input | 1 | Converter busy |
| stat_rd | input | 1 | Status read strobe |
| ara_rd | input | 1 | Alert-response-address read strobe |
| dev_addr | input | 7 | Device 7-bit address |
| status | output | 8 | Status byte |
| alert_pull | output | 1 | Pull-low enable for the shared alert line |
| ara_byte | output | 8 | Alert-response byte |
| ara_ack | output | 1 | Device answers the alert-response read |

## Verification
The bench sweeps every signed reading against several limit pairs. These include negative limits, equal limits and inverted limits, which expose an unsigned comparison or a strict inequality at the boundary value.

Status and alert-response reads are interleaved pseudo-randomly. This catches a design that clears a flag whose latest reading is still beyond its limit, or that lets a status read drop the alert.

Directed cases cover a read colliding with a new event, where a wrong priority loses the fault. They also cover an unstrobed out-of-range reading, which a careless design would flag. Finally, they cover an alert-response read while the latch is clear, which must not answer.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
   localparam int STAT_W   = 8;
   localparam int N_LIMIT  = 4;
   localparam int N_FLAG   = 5;
   // flag vector index, also the descending status order from bit 6
   localparam int F_INT_HI = 0;
   localparam int F_INT_LO = 1;
   localparam int F_REM_HI = 2;
   localparam int F_REM_LO = 3;
   localparam int F_OPEN   = 4;
   localparam int BUSY_BIT = 7;
endpackage

// File: rtl/tsa_limit_chk.sv
module tsa_limit_chk #(
   parameter int TEMP_W     = 8,
   parameter bit SIGNED_CMP = 1'b1,
   parameter bit HIGH_SIDE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] sample,
   input  logic              vld,
   input  logic [TEMP_W-1:0] limit,
   output logic              evt,
   output logic              cond_now
);
   logic trip;
   logic cond_q;

   generate
      if (TEMP_W < 2) begin : g_bad_w
         initial $fatal(1, "tsa_limit_chk: TEMP_W too small");
      end
      if (SIGNED_CMP) begin : g_signed
         if (HIGH_SIDE) begin : g_hi
            assign trip = $signed(sample) >= $signed(limit);
         end else begin : g_lo
            assign trip = $signed(sample) <= $signed(limit);
         end
      end else begin : g_unsigned
         if (HIGH_SIDE) begin : g_hi
            assign trip = sample >= limit;
         end else begin : g_lo
            assign trip = sample <= limit;
         end
      end
   endgenerate

   assign evt      = vld & trip;
   assign cond_now = vld ? trip : cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond_now;
   end

   AST_COND_HELD_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> cond_q == $past(cond_q)); // R5
endmodule

// File: rtl/tsa_sticky_flag.sv
module tsa_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic cond_now,
   input  logic clr_rd,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_evt) flag_q <= 1'b1;
      else if (clr_rd)  flag_q <= cond_now;
   end

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> flag_q); // R8
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_rd && !set_evt && !cond_now) |=> !flag_q); // R7
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_rd && !set_evt) |=> flag_q == $past(flag_q)); // R7
endmodule

// File: rtl/tsa_alert_latch.sv
module tsa_alert_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic any_evt,
   input  logic any_cond,
   input  logic ara_rd,
   input  logic stat_rd,
   output logic alert_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  alert_q <= 1'b0;
      else if (any_evt)            alert_q <= 1'b1;
      else if (ara_rd && !any_cond) alert_q <= 1'b0;
   end

   AST_ALERT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> alert_q); // R9
   AST_STAT_KEEPS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !ara_rd && alert_q) |=> alert_q); // R10
   AST_ARA_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ara_rd && !any_cond && !any_evt) |=> !alert_q); // R11
   AST_ARA_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
      (alert_q && any_cond) |=> alert_q); // R11
endmodule

// File: rtl/tsa_status_alert.sv
module tsa_status_alert #(
   parameter int TEMP_W     = 8,
   parameter int ADDR_W     = 7,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] int_temp,
   input  logic              int_vld,
   input  logic [TEMP_W-1:0] rem_temp,
   input  logic              rem_vld,
   input  logic [TEMP_W-1:0] int_hi_lim,
   input  logic [TEMP_W-1:0] int_lo_lim,
   input  logic [TEMP_W-1:0] rem_hi_lim,
   input  logic [TEMP_W-1:0] rem_lo_lim,
   input  logic              diode_open,
   input  logic              adc_busy,
   input  logic              stat_rd,
   input  logic              ara_rd,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic [7:0]        status,
   output logic              alert_pull,
   output logic [7:0]        ara_byte,
   output logic              ara_ack
);
   import tsa_pkg::*;

   localparam int RESP_W = ADDR_W + 1;

   generate
      if (RESP_W != STAT_W) begin : g_bad_addr
         initial $fatal(1, "tsa_status_alert: ADDR_W must fill the response byte");
      end
   endgenerate

   logic [TEMP_W-1:0] smp  [N_LIMIT];
   logic [TEMP_W-1:0] lim  [N_LIMIT];
   logic              svld [N_LIMIT];
   logic [N_FLAG-1:0] evt;
   logic [N_FLAG-1:0] cond;
   logic [N_FLAG-1:0] flag;
   logic              alert_q;

   assign smp[F_INT_HI]  = int_temp;   assign lim[F_INT_HI] = int_hi_lim;
   assign smp[F_INT_LO]  = int_temp;   assign lim[F_INT_LO] = int_lo_lim;
   assign smp[F_REM_HI]  = rem_temp;   assign lim[F_REM_HI] = rem_hi_lim;
   assign smp[F_REM_LO]  = rem_temp;   assign lim[F_REM_LO] = rem_lo_lim;
   assign svld[F_INT_HI] = int_vld;    assign svld[F_INT_LO] = int_vld;
   assign svld[F_REM_HI] = rem_vld;    assign svld[F_REM_LO] = rem_vld;

   generate
      for (genvar gi = 0; gi < N_LIMIT; gi++) begin : g_lim
         tsa_limit_chk #(
            .TEMP_W    (TEMP_W),
            .SIGNED_CMP(SIGNED_CMP),
            .HIGH_SIDE ((gi % 2) == 0)
         ) u_chk (
            .clk     (clk),
            .rst_n   (rst_n),
            .sample  (smp[gi]),
            .vld     (svld[gi]),
            .limit   (lim[gi]),
            .evt     (evt[gi]),
            .cond_now(cond[gi])
         );
      end
   endgenerate

   assign evt[F_OPEN]  = diode_open;
   assign cond[F_OPEN] = diode_open;

   generate
      for (genvar gf = 0; gf < N_FLAG; gf++) begin : g_flag
         tsa_sticky_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (evt[gf]),
            .cond_now(cond[gf]),
            .clr_rd  (stat_rd),
            .flag_q  (flag[gf])
         );
      end
   endgenerate

   tsa_alert_latch u_alert (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_evt (|evt),
      .any_cond(|cond),
      .ara_rd  (ara_rd),
      .stat_rd (stat_rd),
      .alert_q (alert_q)
   );

   always_comb begin
      status           = '0;
      status[BUSY_BIT] = adc_busy;
      for (int k = 0; k < N_FLAG; k++) status[BUSY_BIT-1-k] = flag[k];
   end

   assign alert_pull = alert_q;
   assign ara_byte   = alert_q ? {dev_addr, 1'b1} : '0;
   assign ara_ack    = alert_q & ara_rd;

   always_comb begin
      AST_RSVD_ZERO: assert (status[1:0] == 2'b00); // R2
   end
   AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_pull |-> (ara_byte == 8'h00 && !ara_ack)); // R12
   AST_FLAG_NEEDS_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|status[6:2]) |-> alert_pull); // R9
endmodule

// File: tb/tsa_status_alert_tb.sv
module tsa_status_alert_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] int_temp = '0, rem_temp = '0;
   logic int_vld = 0, rem_vld = 0;
   logic [7:0] int_hi_lim = '0, int_lo_lim = '0, rem_hi_lim = '0, rem_lo_lim = '0;
   logic diode_open = 0, adc_busy = 0, stat_rd = 0, ara_rd = 0;
   logic [6:0] dev_addr = 7'h4C;
   logic [7:0] status, ara_byte;
   logic alert_pull, ara_ack;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // bench model state, built from the requirements
   bit m_flag [5];
   bit m_cond [4];
   bit m_alert;

   always #5 clk = ~clk;

   tsa_status_alert u_dut (
      .clk(clk), .rst_n(rst_n),
      .int_temp(int_temp), .int_vld(int_vld),
      .rem_temp(rem_temp), .rem_vld(rem_vld),
      .int_hi_lim(int_hi_lim), .int_lo_lim(int_lo_lim),
      .rem_hi_lim(rem_hi_lim), .rem_lo_lim(rem_lo_lim),
      .diode_open(diode_open), .adc_busy(adc_busy),
      .stat_rd(stat_rd), .ara_rd(ara_rd), .dev_addr(dev_addr),
      .status(status), .alert_pull(alert_pull),
      .ara_byte(ara_byte), .ara_ack(ara_ack)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock with current inputs; the model advances in step
   task automatic step();
      bit cmp [4];
      bit vv  [4];
      bit cn  [5];
      bit ev  [5];
      bit any_e, any_c;
      cmp[0] = $signed(int_temp) >= $signed(int_hi_lim);
      cmp[1] = $signed(int_temp) <= $signed(int_lo_lim);
      cmp[2] = $signed(rem_temp) >= $signed(rem_hi_lim);
      cmp[3] = $signed(rem_temp) <= $signed(rem_lo_lim);
      vv[0] = int_vld; vv[1] = int_vld; vv[2] = rem_vld; vv[3] = rem_vld;
      any_e = 0; any_c = 0;
      for (int i = 0; i < 4; i++) begin
         ev[i] = vv[i] && cmp[i];
         cn[i] = vv[i] ? cmp[i] : m_cond[i];
      end
      ev[4] = diode_open; cn[4] = diode_open;
      for (int i = 0; i < 5; i++) begin
         any_e |= ev[i]; any_c |= cn[i];
         if (ev[i]) m_flag[i] = 1;
         else if (stat_rd) m_flag[i] = cn[i];
      end
      for (int i = 0; i < 4; i++) m_cond[i] = cn[i];
      if (any_e) m_alert = 1;
      else if (ara_rd && !any_c) m_alert = 0;
      @(posedge clk); #1;
   endtask

   function automatic logic [7:0] exp_status();
      return {adc_busy, m_flag[0], m_flag[1], m_flag[2], m_flag[3], m_flag[4], 2'b00};
   endfunction

   task automatic check_all(string req);
      check({req, " status"}, status, exp_status());
      check({req, " alert"}, alert_pull, m_alert);
      check({req, " ara_byte"}, ara_byte, m_alert ? {dev_addr, 1'b1} : 8'h00);
   endtask

   task automatic idle();
      int_vld = 0; rem_vld = 0; stat_rd = 0; ara_rd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      logic [7:0] hi_set [4] = '{8'h10, 8'hF0, 8'h00, 8'hE0};
      logic [7:0] lo_set [4] = '{8'hF6, 8'h80, 8'h00, 8'h20};
      for (int i = 0; i < 5; i++) m_flag[i] = 0;
      for (int i = 0; i < 4; i++) m_cond[i] = 0;
      m_alert = 0;
      int_hi_lim = 8'd50; int_lo_lim = 8'd10; rem_hi_lim = 8'd60; rem_lo_lim = 8'd5;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 status", status[6:0], 7'h00);
      check("R1 alert", alert_pull, 0);
      check("R1 ara_byte", ara_byte, 8'h00);
      check("R1 ara_ack", ara_ack, 0);
      rst_n = 1;
      step();
      // R2: busy is live, not sticky
      adc_busy = 1; #1;
      check("R2 busy live", status, 8'h80);
      check("R9 busy no alert", alert_pull, 0);
      adc_busy = 0; #1;
      check("R2 busy drop", status, 8'h00);
      // R12: no response while latch clear
      ara_rd = 1; #1;
      check("R12 no ack idle", ara_ack, 0);
      check("R12 no byte idle", ara_byte, 8'h00);
      step(); idle();
      // R5: unstrobed hot reading ignored
      int_temp = 8'd100; step();
      check("R5 no strobe", status, 8'h00);
      check("R5 no alert", alert_pull, 0);
      // R3 boundary: equal to high limit trips
      int_temp = 8'd50; int_vld = 1; step(); idle();
      check("R3 equal hi", status, 8'h40);
      check("R9 alert set", alert_pull, 1);
      // R12 response byte and ack
      ara_rd = 1; #1;
      check("R12 byte", ara_byte, {dev_addr, 1'b1});
      check("R12 ack", ara_ack, 1);
      ara_rd = 0;
      // R7: read while last reading still hot keeps flag; R10 alert stays
      stat_rd = 1; step(); idle();
      check("R7 persist", status, 8'h40);
      check("R10 stat keeps alert", alert_pull, 1);
      // R11: ARA with persisting condition keeps alert
      ara_rd = 1; step(); idle();
      check("R11 persist", alert_pull, 1);
      // cool reading; R4 boundary just above low: no flag
      int_temp = 8'd11; int_vld = 1; step(); idle();
      stat_rd = 1; step(); idle();
      check("R7 cleared", status, 8'h00);
      check("R10 alert still", alert_pull, 1);
      ara_rd = 1; step(); idle();
      check("R11 released", alert_pull, 0);
      check("R12 byte gone", ara_byte, 8'h00);
      // R4 boundary equal to low
      int_temp = 8'd10; int_vld = 1; step(); idle();
      check("R4 equal lo", status, 8'h20);
      // R8: read and new event in the same cycle
      int_temp = 8'd20; int_vld = 1; step(); idle();
      rem_temp = 8'd70; rem_vld = 1; stat_rd = 1; step(); idle();
      check("R8 event wins", status, 8'h10);
      // R6: diode open every cycle, sticky after release
      diode_open = 1; step(); diode_open = 0; step();
      check("R6 open flag", status[2], 1);
      check_all("R6");
      rem_temp = 8'd30; rem_vld = 1; step(); idle();
      stat_rd = 1; step(); idle();
      ara_rd = 1; step(); idle();
      check_all("R11 clear");
      // sweeps: R3 R4 signed boundaries for both sensors, mixed reads
      for (int s = 0; s < 4; s++) begin
         int_hi_lim = hi_set[s]; int_lo_lim = lo_set[s];
         rem_hi_lim = lo_set[s]; rem_lo_lim = hi_set[s];
         for (int t = 0; t < 256; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            int_temp = t[7:0]; rem_temp = 8'(255 - t);
            int_vld = lfsr[0] | lfsr[1];
            rem_vld = lfsr[2];
            stat_rd = lfsr[3];
            ara_rd = lfsr[4] & lfsr[5];
            diode_open = (lfsr[9:6] == 4'h0);
            adc_busy = lfsr[10];
            step();
            check_all("R3 R4 R7 R11 sweep");
         end
      end
      idle();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule